// File: doc/BRIEF.md
# Guarded Escape-Sequence Detector

This block watches a received byte stream for an escape sequence. The sequence is a programmed number of back-to-back copies of one programmed byte. The copies only count when the line was quiet for a while before the first copy and stays quiet for a while after the last one. Because of these timing guards, the same byte values in ordinary traffic are ignored.

The block takes a one-cycle valid strobe with each received byte and a free-running time-base tick. A single idle timer counts ticks since the most recent byte. A small state machine compares that timer against three programmable limits:
- the pre-guard time, checked at the first matching byte;
- the inter-byte gap limit, checked at each later matching byte;
- the post-guard time, checked after the last matching byte.

When all the conditions hold, the block emits a one-cycle detect pulse. Reporting the sequence to software, or removing the bytes from any buffer, is left to neighbouring logic.

Top module: `esc_seq_detect`

## Requirements
- R1: After reset is released, detect_o is low and the idle timer is zero. A sequence can therefore only start after a full pre-guard time has passed since reset.
- R2: The idle timer clears on every cycle with byte_vld_i high. Otherwise it advances by one on each cycle with tick_i high, and it holds at all-ones instead of wrapping.
- R3: A byte equal to esc_char_i starts a sequence only if, at that byte, the idle timer is greater than or equal to pre_idle_i.
- R4: A later matching byte continues the sequence only if the idle timer is at most gap_tout_i. Otherwise the sequence is dropped, and that byte does not start a new one.
- R5: A byte that differs from esc_char_i while a sequence is in progress drops the sequence.
- R6: The sequence is complete once the number of consecutive matching bytes equals esc_count_i. A value of 0 is treated as 1.
- R7: After completion, any byte that arrives while the idle timer is below post_idle_i, or in the cycle the timer reaches it, discards the sequence.
- R8: A completed sequence that survives the post guard produces exactly one high cycle on detect_o. It registers on the first edge at which the idle timer equals post_idle_i; with tick_i always high, this is post_idle_i+1 edges after the edge that captured the last byte.
- R9: After a discard or a detect, the block again requires a full pre-guard time before a matching byte can start a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick; the idle timer advances on cycles where this is high |
| byte_vld_i | input | 1 | One-cycle strobe marking a received byte |
| byte_i | input | 8 | Received byte value |
| esc_char_i | input | 8 | Byte value that makes up the escape sequence |
| esc_count_i | input | 8 | Number of consecutive matching bytes required (0 acts as 1) |
| pre_idle_i | input | 24 | Minimum idle ticks before the first matching byte |
| gap_tout_i | input | 24 | Maximum idle ticks between matching bytes |
| post_idle_i | input | 24 | Idle ticks required after the last matching byte |
| detect_o | output | 1 | One-cycle pulse on a successful detection |

## Verification
Each pattern is built so that a sequence lands exactly on, or one tick past, one guard limit: pre-guard at 20 versus 19 idle cycles, gap at 5 versus 6, and post-guard with the next byte after 10 versus 11 idle cycles. This separates a `>=` comparison from a `>`, and byte-wins-tie behaviour from tick-wins. Further patterns cover:
- too few and too many matching bytes, and a wrong byte value, which test the count logic;
- a foreign byte in the middle and matches sent right after a discard, which show that the count resets and a fresh pre-guard is required;
- gated and half-rate ticks, which show that time is measured in ticks rather than clock cycles;
- repeat counts of 1 and 0, and the pulse position after the last byte, which pin down the single-byte case and the output latency.

// File: rtl/esc_seq_pkg.sv
package esc_seq_pkg;
  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_RUN  = 2'd1,
    ST_POST = 2'd2
  } esc_st_e;
endpackage

// File: rtl/esc_idle_timer.sv
module esc_idle_timer #(
  parameter int unsigned TW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic [TW-1:0] cnt_o
);
  logic [TW-1:0] cnt_q;
  logic          at_max;

  assign at_max = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (tick_i && !at_max)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
  import esc_seq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 8,
  parameter int unsigned TW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic [DW-1:0] esc_char_i,
  input  logic [CW-1:0] esc_count_i,
  input  logic [TW-1:0] idle_i,
  input  logic [TW-1:0] pre_idle_i,
  input  logic [TW-1:0] gap_tout_i,
  input  logic [TW-1:0] post_idle_i,
  output logic          detect_o
);
  esc_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          det_q, det_d;
  logic          hit;
  logic [CW:0]   need;
  logic [CW:0]   cnt_inc;

  assign hit     = (byte_i == esc_char_i);
  // a zero count behaves as a single-byte sequence
  assign need    = (esc_count_i == '0) ? (CW+1)'(1) : {1'b0, esc_count_i};
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    det_d = 1'b0;
    unique case (st_q)
      ST_ARM: begin
        if (byte_vld_i && hit && (idle_i >= pre_idle_i)) begin
          cnt_d = CW'(1);
          st_d  = (need == (CW+1)'(1)) ? ST_POST : ST_RUN;
        end
      end
      ST_RUN: begin
        if (byte_vld_i) begin
          if (hit && (idle_i <= gap_tout_i)) begin
            cnt_d = cnt_inc[CW-1:0];
            if (cnt_inc >= need) st_d = ST_POST;
          end else begin
            st_d = ST_ARM;
          end
        end
      end
      ST_POST: begin
        // an arriving byte wins over a guard expiring in the same cycle
        if (byte_vld_i) begin
          st_d = ST_ARM;
        end else if (idle_i >= post_idle_i) begin
          det_d = 1'b1;
          st_d  = ST_ARM;
        end
      end
      default: st_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ARM;
      cnt_q <= '0;
      det_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      det_q <= det_d;
    end
  end

  assign detect_o = det_q;
endmodule

// File: rtl/esc_seq_detect.sv
module esc_seq_detect #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 8,
  parameter int unsigned TW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic [DW-1:0] esc_char_i,
  input  logic [CW-1:0] esc_count_i,
  input  logic [TW-1:0] pre_idle_i,
  input  logic [TW-1:0] gap_tout_i,
  input  logic [TW-1:0] post_idle_i,
  output logic          detect_o
);
  logic [TW-1:0] idle_cnt;

  esc_idle_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (byte_vld_i),
    .tick_i (tick_i),
    .cnt_o  (idle_cnt)
  );

  esc_seq_fsm #(.DW(DW), .CW(CW), .TW(TW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .esc_char_i  (esc_char_i),
    .esc_count_i (esc_count_i),
    .idle_i      (idle_cnt),
    .pre_idle_i  (pre_idle_i),
    .gap_tout_i  (gap_tout_i),
    .post_idle_i (post_idle_i),
    .detect_o    (detect_o)
  );
endmodule

// File: rtl/esc_seq_detect_chk.sv
module esc_seq_detect_chk #(
  parameter int unsigned TW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          byte_vld_i,
  input logic [TW-1:0] tmr_i,
  input logic [TW-1:0] post_idle_i,
  input logic          detect_o
);
  AST_TMR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i |=> (tmr_i == '0)); // R2

  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_vld_i && tick_i && !(&tmr_i)) |=> (tmr_i == $past(tmr_i) + 1'b1)); // R2

  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_vld_i && (!tick_i || (&tmr_i))) |=> $stable(tmr_i)); // R2

  AST_DET_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |=> !detect_o); // R8

  AST_DET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(detect_o) |-> !$past(byte_vld_i)); // R7

  AST_DET_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(detect_o) |-> ($past(tmr_i) >= $past(post_idle_i))); // R7
endmodule

bind esc_seq_detect esc_seq_detect_chk #(.TW(TW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .byte_vld_i  (byte_vld_i),
  .tmr_i       (idle_cnt),
  .post_idle_i (post_idle_i),
  .detect_o    (detect_o)
);

// File: tb/esc_seq_detect_tb_top.sv
module esc_seq_detect_tb_top;
  localparam logic [7:0] ESC = 8'h2B;

  typedef struct packed {
    int         pre;
    int         gap;
    int         nb;
    logic [7:0] val;
    int         exp;
    int         req;
  } vec_t;

  // pre = 20, gap = 5, post = 10, count = 3
  localparam vec_t VECS [8] = '{
    '{20, 2, 3, ESC,   1, 3},  // R3 pre-guard met exactly
    '{19, 2, 3, ESC,   0, 3},  // R3 pre-guard one short
    '{25, 5, 3, ESC,   1, 4},  // R4 gap at limit
    '{25, 6, 3, ESC,   0, 4},  // R4 gap one over
    '{25, 2, 2, ESC,   0, 6},  // R6 too few
    '{25, 2, 4, ESC,   0, 7},  // R7 extra match inside post guard
    '{25, 2, 3, 8'h2A, 0, 3},  // R3 wrong value
    '{25, 1, 5, ESC,   0, 6}   // R6 overlong run
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [7:0]  esc_char_i = ESC;
  logic [7:0]  esc_count_i = 8'd3;
  logic [23:0] pre_idle_i = 24'd20;
  logic [23:0] gap_tout_i = 24'd5;
  logic [23:0] post_idle_i = 24'd10;
  logic        detect_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int step_idx = 0;
  int last_pulse = -1;

  always #10 clk_i = ~clk_i;

  esc_seq_detect dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .esc_char_i  (esc_char_i),
    .esc_count_i (esc_count_i),
    .pre_idle_i  (pre_idle_i),
    .gap_tout_i  (gap_tout_i),
    .post_idle_i (post_idle_i),
    .detect_o    (detect_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge; inputs set at negedge, output sampled at next negedge
  task automatic step(input logic v, input logic [7:0] d);
    byte_vld_i = v;
    byte_i     = d;
    @(negedge clk_i);
    if (detect_o) begin
      pulses++;
      last_pulse = step_idx;
    end
    step_idx++;
    byte_vld_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 8'h00);
  endtask

  task automatic burst(input int n, input int gap, input logic [7:0] v);
    for (int k = 0; k < n; k++) begin
      if (k > 0) idle(gap);
      step(1'b1, v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 reset detect low", int'(detect_o), 0);

    // R1: timer starts at zero, so a run right after reset is rejected
    pulses = 0;
    burst(3, 1, ESC);
    idle(40);
    chk("R1 no start right after reset", pulses, 0);

    foreach (VECS[i]) begin
      pulses = 0;
      step(1'b1, 8'h00);
      idle(VECS[i].pre);
      burst(VECS[i].nb, VECS[i].gap, VECS[i].val);
      idle(40);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), pulses, VECS[i].exp);
    end

    // R8: pulse position and width
    pulses = 0;
    step(1'b1, 8'h00);
    idle(20);
    burst(2, 1, ESC);
    base = step_idx;
    step(1'b1, ESC);
    idle(40);
    chk("R8 single pulse", pulses, 1);
    chk("R8 latency after last byte", last_pulse - base, 11);

    // R7: byte at the very cycle the post guard is reached wins
    pulses = 0;
    step(1'b1, 8'h00);
    idle(20);
    burst(3, 1, ESC);
    idle(10);
    step(1'b1, 8'h00);
    idle(40);
    chk("R7 byte at post limit discards", pulses, 0);

    // R7: one more idle cycle lets the guard expire first
    pulses = 0;
    step(1'b1, 8'h00);
    idle(20);
    burst(3, 1, ESC);
    idle(11);
    step(1'b1, 8'h00);
    idle(40);
    chk("R7 byte after post limit keeps detect", pulses, 1);

    // R5: foreign byte inside the run
    pulses = 0;
    step(1'b1, 8'h00);
    idle(20);
    step(1'b1, ESC);
    idle(1);
    step(1'b1, 8'h00);
    idle(1);
    burst(2, 1, ESC);
    idle(40);
    chk("R5 foreign byte drops run", pulses, 0);

    // R9: after a discard, fresh matches need a new pre guard
    pulses = 0;
    step(1'b1, 8'h00);
    idle(20);
    burst(4, 2, ESC);
    idle(2);
    burst(3, 2, ESC);
    idle(40);
    chk("R9 no restart without pre guard", pulses, 0);
    pulses = 0;
    idle(20);
    burst(3, 2, ESC);
    idle(40);
    chk("R9 restart after fresh pre guard", pulses, 1);

    // R4: gap overrun match must not itself start a new run
    pulses = 0;
    step(1'b1, 8'h00);
    idle(20);
    step(1'b1, ESC);
    idle(8);
    burst(2, 1, ESC);
    idle(40);
    chk("R4 late match does not restart", pulses, 0);

    // R2: timer only advances on ticks
    pulses = 0;
    step(1'b1, 8'h00);
    tick_i = 1'b0;
    idle(30);
    tick_i = 1'b1;
    burst(3, 1, ESC);
    idle(40);
    chk("R2 no ticks no pre guard", pulses, 0);
    pulses = 0;
    step(1'b1, 8'h00);
    for (int k = 0; k < 40; k++) begin
      tick_i = k[0];
      step(1'b0, 8'h00);
    end
    tick_i = 1'b1;
    burst(3, 1, ESC);
    idle(40);
    chk("R2 half-rate ticks reach pre guard", pulses, 1);

    // R6: count of one and of zero
    esc_count_i = 8'd1;
    pulses = 0;
    step(1'b1, 8'h00);
    idle(20);
    step(1'b1, ESC);
    idle(40);
    chk("R6 count one", pulses, 1);
    esc_count_i = 8'd0;
    pulses = 0;
    step(1'b1, 8'h00);
    idle(20);
    step(1'b1, ESC);
    idle(40);
    chk("R6 count zero acts as one", pulses, 1);
    esc_count_i = 8'd3;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule